// File: doc/BRIEF.md
# Test output selector with bypass

This block picks what appears on a single diagnostic pin of a clock synthesizer. A 3-bit select chooses one of eight sources: the serial output of the configuration shift register, the phase reference, the pulse train of a programmable loop-modulus counter, the main output, a quarter-rate copy of the main output, or a fixed high or low level. The block holds the 9-bit loop-modulus counter and the output divider. In normal operation both run on the oscillator clock.

One select code puts the part into bypass. The serial clock then replaces the oscillator as the clock for both dividers. The output divider drives the main output, and the loop counter drives the diagnostic pin, so a board can step the divider chain one slow clock at a time. The change between the two clock sources goes through a glitch-free switch. Each clock has its own small state machine with a two-stage synchronizer. A leg only enables its clock after it has seen the other leg switch off. The enable itself changes on the falling edge, while that clock is low.

Each clock leg's state machine has three states. GATE_OFF leaves the clock blocked. When the leg is wanted and the other leg is seen as off, it moves to GATE_ARM, a one-cycle confirmation. If the condition still holds, GATE_ARM moves to GATE_ON; otherwise it returns to GATE_OFF. GATE_ON lets the clock through and falls back to GATE_OFF as soon as the synchronized request drops. The clock enable follows GATE_ON on the next falling edge.

Top module: `diag_tap_mux`

## Requirements
- R1: While `rst_n` is low, with select 000, `test_out` and `main_out` are both low, even if `sr_tap` is high.
- R2: Select 001 holds `test_out` high and select 101 holds it low.
- R3: With select 000, `test_out` at each serial-clock falling edge equals `sr_tap` as captured at the preceding serial-clock rising edge.
- R4: With select 010, `test_out` at each oscillator falling edge equals `ref_in` as captured at the preceding oscillator rising edge.
- R5: With select 011 and modulus M of 2 or more, `test_out` is a pulse train with a period of M oscillator cycles, high for exactly one cycle per period. A new modulus takes effect at the next terminal count.
- R6: A modulus of 0 or 1 acts as divide-by-one, so the loop output is high on every cycle.
- R7: `main_out` is the output divider, coded by `out_nsel`: 00 divides by 2, 01 by 4, 10 by 8 (all with 50% duty), and 11 passes the divider clock straight through. Select 100 copies `main_out` to `test_out`.
- R8: With select 111, `test_out` is `main_out` divided by a further 4 at 50% duty. For code 11 this means the clock divided by 4.
- R9: With select 110 (bypass), both dividers run on `clk_ser`. `test_out` carries the loop pulse with a period of M serial cycles, and `main_out` divides the serial clock by the `out_nsel` ratio.
- R10: The two clock sources are never enabled at the same time. After leaving bypass, the loop period is again counted in oscillator cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock that drives the dividers in normal operation |
| clk_ser | input | 1 | Serial clock; drives the dividers in bypass |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Phase reference, captured on the oscillator clock |
| sr_tap | input | 1 | Serial output of the configuration shift register |
| loop_mod | input | 9 | Loop-counter modulus M |
| out_nsel | input | 2 | Output divider code (00 /2, 01 /4, 10 /8, 11 /1) |
| test_sel | input | 3 | Diagnostic source select |
| test_out | output | 1 | Diagnostic output |
| main_out | output | 1 | Output divider result |

## Verification
The properties assume that `test_sel`, `loop_mod` and `out_nsel` are configuration values held steady for many cycles of both clocks. They also assume that `sr_tap` and `ref_in` change away from the rising edge of the clock that captures them. The tap and reference properties only apply once the select has been stable for a full sampling interval. The pulse and toggle properties only apply after the divider clock has produced a few edges since reset. The stimulus follows these assumptions: it changes configuration only between measurements, waits longer than the largest old modulus plus the switch handshake before it samples again, and drives serial and reference data on falling edges.

// File: rtl/dtm_pkg.sv
package dtm_pkg;

    typedef enum logic [2:0] {
        TS_SHIFT  = 3'd0,
        TS_HIGH   = 3'd1,
        TS_REF    = 3'd2,
        TS_LOOP   = 3'd3,
        TS_MAIN   = 3'd4,
        TS_LOW    = 3'd5,
        TS_BYPASS = 3'd6,
        TS_QUART  = 3'd7
    } tsel_e;

    typedef enum logic [1:0] {
        GATE_OFF = 2'd0,
        GATE_ARM = 2'd1,
        GATE_ON  = 2'd2
    } gate_st_e;

endpackage

// File: rtl/dtm_clk_leg.sv
// One leg of the glitch-free clock switch: a request synchronizer, a
// three-state arming machine and a falling-edge enable register.
module dtm_clk_leg
    import dtm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic peer_on,
    output logic gate_en
);

    logic [SYNC_STAGES-1:0] want_sh;
    logic [SYNC_STAGES-1:0] peer_sh;
    logic                   want_s;
    logic                   peer_s;
    logic                   may_run;
    gate_st_e               st_q;
    gate_st_e               st_d;

    // Peer is assumed on after reset so nothing runs before it is seen off.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            want_sh <= '0;
            peer_sh <= '1;
        end else begin
            want_sh <= {want_sh[SYNC_STAGES-2:0], want};
            peer_sh <= {peer_sh[SYNC_STAGES-2:0], peer_on};
        end
    end

    assign want_s  = want_sh[SYNC_STAGES-1];
    assign peer_s  = peer_sh[SYNC_STAGES-1];
    assign may_run = want_s && !peer_s;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= GATE_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            GATE_OFF: if (may_run) st_d = GATE_ARM;
            GATE_ARM: st_d = may_run ? GATE_ON : GATE_OFF;
            GATE_ON:  if (!want_s) st_d = GATE_OFF;
            default:  st_d = GATE_OFF;
        endcase
    end

    // Output: the enable moves only while the clock is low.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_en <= 1'b0;
        end else begin
            gate_en <= (st_q == GATE_ON);
        end
    end

endmodule

// File: rtl/dtm_loop_div.sv
// Loop-modulus counter: reloads M-1, counts down, one-cycle pulse at zero.
module dtm_loop_div #(
    parameter int MOD_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MOD_W-1:0] modulus,
    output logic             pulse
);

    logic [MOD_W-1:0] cnt_q;
    logic             at_zero;
    logic             tiny_mod;

    assign at_zero  = (cnt_q == '0);
    assign tiny_mod = (modulus <= MOD_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= at_zero;
            if (at_zero) begin
                cnt_q <= tiny_mod ? '0 : modulus - MOD_W'(1);
            end else begin
                cnt_q <= cnt_q - MOD_W'(1);
            end
        end
    end

endmodule

// File: rtl/dtm_out_div.sv
// Output divider: code k (not all ones) divides by 2^(k+1); all ones passes
// the clock. A quarter-rate copy comes from two bits further up.
module dtm_out_div #(
    parameter  int NSEL_W = 2,
    localparam int DIV_W  = (1 << NSEL_W) + 1,
    localparam int IDX_W  = $clog2(DIV_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSEL_W-1:0] nsel,
    output logic              main,
    output logic              quarter
);

    logic [DIV_W-1:0] cnt_q;
    logic [IDX_W-1:0] q_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    assign q_idx = IDX_W'(nsel) + IDX_W'(2);

    always_comb begin
        if (nsel == '1) begin
            main    = clk;
            quarter = cnt_q[1];
        end else begin
            main    = cnt_q[nsel];
            quarter = cnt_q[q_idx];
        end
    end

endmodule

// File: rtl/diag_tap_mux.sv
module diag_tap_mux
    import dtm_pkg::*;
#(
    parameter int MOD_W       = 9,
    parameter int NSEL_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_osc,
    input  logic              clk_ser,
    input  logic              rst_n,
    input  logic              ref_in,
    input  logic              sr_tap,
    input  logic [MOD_W-1:0]  loop_mod,
    input  logic [NSEL_W-1:0] out_nsel,
    input  logic [2:0]        test_sel,
    output logic              test_out,
    output logic              main_out
);

    localparam int LEGS = 2;   // index 0: oscillator, 1: serial clock

    tsel_e          sel;
    logic           in_bypass;
    logic [LEGS-1:0] leg_clk;
    logic [LEGS-1:0] leg_want;
    logic [LEGS-1:0] leg_en;
    logic           en_osc;
    logic           en_ser;
    logic           clk_core;
    logic           loop_pulse;
    logic           main_div;
    logic           quarter_div;
    logic           sr_q;
    logic           ref_q;

    assign sel       = tsel_e'(test_sel);
    assign in_bypass = (sel == TS_BYPASS);

    assign leg_clk  = {clk_ser, clk_osc};
    assign leg_want = {in_bypass, !in_bypass};

    for (genvar g = 0; g < LEGS; g++) begin : g_leg
        dtm_clk_leg #(
            .SYNC_STAGES(SYNC_STAGES)
        ) u_leg (
            .clk    (leg_clk[g]),
            .rst_n  (rst_n),
            .want   (leg_want[g]),
            .peer_on(leg_en[LEGS-1-g]),
            .gate_en(leg_en[g])
        );
    end

    assign en_osc   = leg_en[0];
    assign en_ser   = leg_en[1];
    assign clk_core = (clk_osc & en_osc) | (clk_ser & en_ser);

    dtm_loop_div #(
        .MOD_W(MOD_W)
    ) u_loop (
        .clk    (clk_core),
        .rst_n  (rst_n),
        .modulus(loop_mod),
        .pulse  (loop_pulse)
    );

    dtm_out_div #(
        .NSEL_W(NSEL_W)
    ) u_odiv (
        .clk    (clk_core),
        .rst_n  (rst_n),
        .nsel   (out_nsel),
        .main   (main_div),
        .quarter(quarter_div)
    );

    // Each data source is registered on its own clock.
    always_ff @(posedge clk_ser or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= 1'b0;
        end else begin
            sr_q <= sr_tap;
        end
    end

    always_ff @(posedge clk_osc or negedge rst_n) begin
        if (!rst_n) begin
            ref_q <= 1'b0;
        end else begin
            ref_q <= ref_in;
        end
    end

    always_comb begin
        unique case (sel)
            TS_SHIFT:          test_out = sr_q;
            TS_HIGH:           test_out = 1'b1;
            TS_REF:            test_out = ref_q;
            TS_LOOP,
            TS_BYPASS:         test_out = loop_pulse;
            TS_MAIN:           test_out = main_div;
            TS_LOW:            test_out = 1'b0;
            TS_QUART:          test_out = quarter_div;
            default:           test_out = 1'b0;
        endcase
    end

    assign main_out = main_div;

endmodule

// File: rtl/dtm_sva.sv
module dtm_sva
    import dtm_pkg::*;
#(
    parameter int MOD_W  = 9,
    parameter int NSEL_W = 2
) (
    input logic              clk_osc,
    input logic              clk_ser,
    input logic              clk_core,
    input logic              rst_n,
    input logic [2:0]        test_sel,
    input logic              sr_tap,
    input logic              ref_in,
    input logic [MOD_W-1:0]  loop_mod,
    input logic [NSEL_W-1:0] out_nsel,
    input logic              test_out,
    input logic              main_out,
    input logic              loop_pulse,
    input logic              en_osc,
    input logic              en_ser
);

    logic [1:0] warm_core;
    logic [1:0] warm_ser;
    logic [1:0] warm_osc;

    always_ff @(posedge clk_core or negedge rst_n) begin
        if (!rst_n) warm_core <= '0;
        else if (warm_core != 2'd3) warm_core <= warm_core + 2'd1;
    end

    always_ff @(posedge clk_ser or negedge rst_n) begin
        if (!rst_n) warm_ser <= '0;
        else if (warm_ser != 2'd3) warm_ser <= warm_ser + 2'd1;
    end

    always_ff @(posedge clk_osc or negedge rst_n) begin
        if (!rst_n) warm_osc <= '0;
        else if (warm_osc != 2'd3) warm_osc <= warm_osc + 2'd1;
    end

    // R10: never both clock legs enabled
    a_r10_one_leg_osc: assert property (@(posedge clk_osc) disable iff (!rst_n)
        !(en_osc && en_ser));
    a_r10_one_leg_ser: assert property (@(posedge clk_ser) disable iff (!rst_n)
        !(en_osc && en_ser));

    // R5: loop pulse lasts one cycle when M > 1
    a_r5_pulse_narrow: assert property (@(posedge clk_core) disable iff (!rst_n)
        (warm_core == 2'd3 && loop_pulse && $past(loop_mod) > MOD_W'(1)) |=> !loop_pulse);

    // R7: divide-by-2 output flips every divider clock
    a_r7_half_toggle: assert property (@(posedge clk_core) disable iff (!rst_n)
        (warm_core == 2'd3 && out_nsel == '0 && $past(out_nsel) == '0)
        |-> main_out != $past(main_out));

    // R3: tap follows one serial edge late
    a_r3_tap_follow: assert property (@(posedge clk_ser) disable iff (!rst_n)
        (warm_ser == 2'd3 && test_sel == TS_SHIFT && $past(test_sel) == TS_SHIFT)
        |-> test_out == $past(sr_tap));

    // R4: reference follows one oscillator edge late
    a_r4_ref_follow: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (warm_osc == 2'd3 && test_sel == TS_REF && $past(test_sel) == TS_REF)
        |-> test_out == $past(ref_in));

endmodule

bind diag_tap_mux dtm_sva #(
    .MOD_W (MOD_W),
    .NSEL_W(NSEL_W)
) u_sva (
    .clk_osc   (clk_osc),
    .clk_ser   (clk_ser),
    .clk_core  (clk_core),
    .rst_n     (rst_n),
    .test_sel  (test_sel),
    .sr_tap    (sr_tap),
    .ref_in    (ref_in),
    .loop_mod  (loop_mod),
    .out_nsel  (out_nsel),
    .test_out  (test_out),
    .main_out  (main_out),
    .loop_pulse(loop_pulse),
    .en_osc    (en_osc),
    .en_ser    (en_ser)
);

// File: tb/test_diag_tap_mux.sv
module test_diag_tap_mux;

    localparam int MOD_W  = 9;
    localparam int NSEL_W = 2;

    logic              clk_osc  = 1'b0;
    logic              clk_ser  = 1'b0;
    logic              rst_n    = 1'b0;
    logic              ref_in   = 1'b0;
    logic              sr_tap   = 1'b0;
    logic [MOD_W-1:0]  loop_mod = 9'd5;
    logic [NSEL_W-1:0] out_nsel = 2'd0;
    logic [2:0]        test_sel = 3'd0;
    logic              test_out;
    logic              main_out;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5ns clk_osc = ~clk_osc;   // 200 MHz
    always #7ns   clk_ser = ~clk_ser;

    diag_tap_mux #(
        .MOD_W (MOD_W),
        .NSEL_W(NSEL_W)
    ) i_diag_tap_mux (
        .clk_osc (clk_osc),
        .clk_ser (clk_ser),
        .rst_n   (rst_n),
        .ref_in  (ref_in),
        .sr_tap  (sr_tap),
        .loop_mod(loop_mod),
        .out_nsel(out_nsel),
        .test_sel(test_sel),
        .test_out(test_out),
        .main_out(main_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_ratio(input logic [1:0] code);
        case (code)
            2'd0:    return 2;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_loop(input int m);
        return (m <= 1) ? 1 : m;
    endfunction

    task automatic tick(input bit on_ser);
        if (on_ser) @(negedge clk_ser);
        else        @(negedge clk_osc);
    endtask

    function automatic logic pick(input bit use_main);
        return use_main ? main_out : test_out;
    endfunction

    // Period and high time, in samples at falling edges of the chosen clock.
    task automatic measure(input bit on_ser, input bit use_main,
                           output int per, output int hi);
        logic prev;
        logic cur;
        int   guard;
        per   = -1;
        hi    = -1;
        guard = 0;
        tick(on_ser);
        prev = pick(use_main);
        forever begin
            tick(on_ser);
            cur = pick(use_main);
            if (!prev && cur) break;
            prev = cur;
            guard++;
            if (guard > 3000) return;
        end
        per   = 1;
        hi    = 1;
        prev  = 1'b1;
        guard = 0;
        forever begin
            tick(on_ser);
            cur = pick(use_main);
            if (!prev && cur) break;
            if (cur) hi++;
            per++;
            prev = cur;
            guard++;
            if (guard > 3000) begin
                per = -1;
                return;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk_osc);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int per;
        int hi;
        int m;
        logic [1:0] code;
        void'($urandom(32'd20240611));

        // R1: reset state
        sr_tap = 1'b1;
        repeat (4) begin
            @(negedge clk_osc);
            check("R1 test_out in reset", int'(test_out), 0);
            check("R1 main_out in reset", int'(main_out), 0);
        end
        @(negedge clk_osc);
        rst_n = 1'b1;
        repeat (40) @(negedge clk_osc);

        // R2: constant levels
        test_sel = 3'd1;
        repeat (6) begin
            @(negedge clk_osc);
            check("R2 constant high", int'(test_out), 1);
        end
        test_sel = 3'd5;
        repeat (6) begin
            @(negedge clk_osc);
            check("R2 constant low", int'(test_out), 0);
        end

        // R3: shift tap registered on serial clock
        test_sel = 3'd0;
        @(negedge clk_ser);
        for (int i = 0; i < 24; i++) begin
            logic v;
            v = 1'($urandom_range(0, 1));
            sr_tap = v;
            @(negedge clk_ser);
            check("R3 shift tap", int'(test_out), int'(v));
        end

        // R4: reference registered on oscillator clock
        test_sel = 3'd2;
        @(negedge clk_osc);
        for (int i = 0; i < 24; i++) begin
            logic v;
            v = 1'($urandom_range(0, 1));
            ref_in = v;
            @(negedge clk_osc);
            check("R4 reference", int'(test_out), int'(v));
        end

        // R5: loop pulse period, directed and random moduli
        test_sel = 3'd3;
        for (int i = 0; i < 8; i++) begin
            if (i == 0)      m = 2;
            else if (i == 1) m = 3;
            else if (i == 2) m = 511;
            else             m = int'($urandom_range(4, 60));
            loop_mod = MOD_W'(m);
            repeat (530) @(negedge clk_osc);
            measure(1'b0, 1'b0, per, hi);
            check("R5 loop period", per, exp_loop(m));
            check("R5 loop high time", hi, 1);
        end

        // R6: modulus 0 and 1 are divide-by-one
        for (int k = 0; k < 2; k++) begin
            loop_mod = MOD_W'(k);
            repeat (80) @(negedge clk_osc);
            for (int j = 0; j < 12; j++) begin
                @(negedge clk_osc);
                check("R6 tiny modulus pulse", int'(test_out), 1);
            end
        end

        // R7: output divider codes, via select 100 and the main pin
        test_sel = 3'd4;
        for (int c = 0; c < 3; c++) begin
            code = 2'(c);
            out_nsel = code;
            repeat (20) @(negedge clk_osc);
            measure(1'b0, 1'b0, per, hi);
            check("R7 select main period", per, exp_ratio(code));
            check("R7 select main high", hi, exp_ratio(code) / 2);
            measure(1'b0, 1'b1, per, hi);
            check("R7 main_out period", per, exp_ratio(code));
        end
        out_nsel = 2'd3;
        repeat (4) @(negedge clk_osc);
        for (int j = 0; j < 4; j++) begin
            @(posedge clk_osc);
            #1ns;
            check("R7 divide-by-one high phase", int'(main_out), 1);
            @(negedge clk_osc);
            #1ns;
            check("R7 divide-by-one low phase", int'(main_out), 0);
        end

        // R8: quarter-rate copy
        test_sel = 3'd7;
        for (int c = 0; c < 4; c++) begin
            code = 2'(c);
            out_nsel = code;
            repeat (40) @(negedge clk_osc);
            measure(1'b0, 1'b0, per, hi);
            check("R8 quarter period", per, 4 * exp_ratio(code));
            check("R8 quarter high", hi, 2 * exp_ratio(code));
        end

        // R9: bypass, dividers on serial clock
        out_nsel = 2'd0;
        loop_mod = 9'd7;
        test_sel = 3'd6;
        repeat (120) @(negedge clk_ser);
        for (int i = 0; i < 4; i++) begin
            if (i == 0) m = 7;
            else        m = int'($urandom_range(2, 40));
            code = 2'($urandom_range(0, 2));
            loop_mod = MOD_W'(m);
            out_nsel = code;
            repeat (100) @(negedge clk_ser);
            measure(1'b1, 1'b0, per, hi);
            check("R9 bypass loop period", per, m);
            check("R9 bypass loop high", hi, 1);
            measure(1'b1, 1'b1, per, hi);
            check("R9 bypass main period", per, exp_ratio(code));
        end

        // R10: leave bypass, loop period back in oscillator cycles
        m = int'($urandom_range(5, 40));
        loop_mod = MOD_W'(m);
        test_sel = 3'd3;
        repeat (300) @(negedge clk_osc);
        measure(1'b0, 1'b0, per, hi);
        check("R10 period after bypass", per, m);
        check("R10 high after bypass", hi, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule